// File: doc/BRIEF.md
# Bridge Memory Window Address Decoder

This block sits on the downstream side of a bridge port and decides whether a memory request address belongs to the port. Two windows are programmed through a small register write port. One window is for non-prefetchable memory and one is for prefetchable memory. Each window is defined by a base field and a limit field at 1 MB granularity. The prefetchable window also has 32-bit upper base and upper limit fields, so it can be placed anywhere in a 64-bit address space. The non-prefetchable window stays below 4 GB. A single memory-access enable bit gates both windows.

Each request presents a valid strobe and a 64-bit address. One cycle later the block returns four things: a response valid, a hit flag, a flag that tells which window matched, and a write-combining attribute. The attribute is raised only for prefetchable hits. Configuration writes change the decode from the next cycle onward. After reset both windows are empty and the enable bit is clear, so nothing is claimed until software programs the block.

Top module: `mem_window_decoder`

## Requirements
- R1: After reset the enable bit is 0, both base fields are all ones, and all limit fields, including the upper limit, are zero. All outputs are low during reset. No address hits until the windows are reprogrammed, even once the enable bit has been set.
- R2: A window covers the addresses from its base field shifted left by 20 up to its limit field shifted left by 20 with the low 20 bits set to ones. Both ends are inclusive.
- R3: The non-prefetchable window can only match addresses whose bits [63:32] are all zero.
- R4: The prefetchable window compares the 44-bit value {upper field, 12-bit field} against address bits [63:20]. This places it above 4 GB when the upper fields are nonzero.
- R5: While the enable bit is 0, no request hits.
- R6: A window whose base value is greater than its limit value never hits.
- R7: When an address lies in both windows, the response reports a hit with the prefetchable flag set.
- R8: The write-combining output is 1 exactly when the response is a prefetchable hit.
- R9: The response valid is the request valid from the previous cycle. Hit, prefetchable and write-combining are 0 whenever the response valid is 0.
- R10: Configuration writes use these select encodings. 0 is the enable bit (data bit 0). 1 is the memory base and 2 is the memory limit. 3 is the prefetchable base and 4 is the prefetchable limit. For selects 1 to 4 the value is data bits [11:0]. 5 is the prefetchable upper base and 6 is the prefetchable upper limit, each taking data bits [31:0]. A write to select 7 changes nothing.
- R11: A write affects only requests that arrive in later cycles. A request in the same cycle as a write is decoded with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Request address valid |
| req_addr_i | input | 64 | Request address |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_hit_o | output | 1 | Address claimed by a window |
| rsp_pref_o | output | 1 | Claiming window is the prefetchable one |
| rsp_wc_o | output | 1 | Write-combining attribute of the claim |

## Verification
The assertions assume that the request valid, the write strobe and the select are defined 0 or 1 values at every sampled edge after reset. They also assume that the configuration values seen by the checker are the ones in force for a request in that same cycle. The bench drives every input with a defined value from time zero, on the falling clock edge only, so each rising edge samples stable data. Writes and requests are sometimes issued in the same cycle so that the old-value rule is exercised.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
    localparam int FIELD_W  = 12;
    localparam int UPPER_W  = 32;
    localparam int GRAN_W   = 20;
    localparam int KEY_W    = UPPER_W + FIELD_W;
    localparam int ADDR_W   = KEY_W + GRAN_W;
    localparam int CFG_AW   = 3;
    localparam int CFG_DW   = 32;
    localparam int NUM_WIN  = 2;
    localparam int WIN_MEM  = 0;
    localparam int WIN_PREF = 1;

    typedef enum logic [CFG_AW-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_MBASE  = 3'd1,
        SEL_MLIM   = 3'd2,
        SEL_PBASE  = 3'd3,
        SEL_PLIM   = 3'd4,
        SEL_PUBASE = 3'd5,
        SEL_PULIM  = 3'd6,
        SEL_NONE   = 3'd7
    } cfg_sel_e;

    typedef struct packed {
        logic               en;
        logic [FIELD_W-1:0] mem_base;
        logic [FIELD_W-1:0] mem_lim;
        logic [FIELD_W-1:0] pf_base;
        logic [FIELD_W-1:0] pf_lim;
        logic [UPPER_W-1:0] pf_ubase;
        logic [UPPER_W-1:0] pf_ulim;
    } win_cfg_t;

    typedef struct packed {
        logic vld;
        logic hit;
        logic pref;
        logic wc;
    } dec_rsp_t;
endpackage

// File: rtl/mwd_regfile.sv
module mwd_regfile
    import mwd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [CFG_AW-1:0] addr_i,
    input  logic [CFG_DW-1:0] wdata_i,
    output win_cfg_t          cfg_o
);
    win_cfg_t cfg_d, cfg_q;
    cfg_sel_e sel;

    assign sel = cfg_sel_e'(addr_i);

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            unique case (sel)
                SEL_CTRL:   cfg_d.en       = wdata_i[0];
                SEL_MBASE:  cfg_d.mem_base = wdata_i[FIELD_W-1:0];
                SEL_MLIM:   cfg_d.mem_lim  = wdata_i[FIELD_W-1:0];
                SEL_PBASE:  cfg_d.pf_base  = wdata_i[FIELD_W-1:0];
                SEL_PLIM:   cfg_d.pf_lim   = wdata_i[FIELD_W-1:0];
                SEL_PUBASE: cfg_d.pf_ubase = wdata_i[UPPER_W-1:0];
                SEL_PULIM:  cfg_d.pf_ulim  = wdata_i[UPPER_W-1:0];
                default:    cfg_d          = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q.en       <= 1'b0;
            cfg_q.mem_base <= '1;
            cfg_q.mem_lim  <= '0;
            cfg_q.pf_base  <= '1;
            cfg_q.pf_lim   <= '0;
            cfg_q.pf_ubase <= '1;
            cfg_q.pf_ulim  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/mwd_window_cmp.sv
module mwd_window_cmp #(
    parameter int KEY_W  = 44,
    parameter int GRAN_W = 20,
    localparam int ADDR_W = KEY_W + GRAN_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [KEY_W-1:0]  base_i,
    input  logic [KEY_W-1:0]  limit_i,
    output logic              match_o
);
    logic [ADDR_W-1:0] lo_full;
    logic [ADDR_W-1:0] hi_full;
    logic              valid_win;

    always_comb begin
        lo_full   = {base_i, {GRAN_W{1'b0}}};
        hi_full   = {limit_i, {GRAN_W{1'b1}}};
        valid_win = (base_i <= limit_i);
        match_o   = valid_win && (addr_i >= lo_full) && (addr_i <= hi_full);
    end
endmodule

// File: rtl/mwd_resp.sv
module mwd_resp
    import mwd_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_valid_i,
    input  logic               en_i,
    input  logic [NUM_WIN-1:0] match_i,
    output dec_rsp_t           rsp_o
);
    dec_rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d      = '0;
        rsp_d.vld  = req_valid_i;
        rsp_d.hit  = req_valid_i && en_i && (|match_i);
        rsp_d.pref = rsp_d.hit && match_i[WIN_PREF];
        rsp_d.wc   = rsp_d.pref;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rsp_q <= '0;
        else         rsp_q <= rsp_d;
    end

    assign rsp_o = rsp_q;
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
    import mwd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [CFG_DW-1:0] cfg_wdata_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic              rsp_pref_o,
    output logic              rsp_wc_o
);
    win_cfg_t           cfg_q;
    dec_rsp_t           rsp;
    logic [KEY_W-1:0]   win_base [NUM_WIN];
    logic [KEY_W-1:0]   win_lim  [NUM_WIN];
    logic [NUM_WIN-1:0] win_match;

    mwd_regfile i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg_q)
    );

    // The low window is zero-extended, which confines it below 4 GB.
    always_comb begin
        win_base[WIN_MEM]  = {{UPPER_W{1'b0}}, cfg_q.mem_base};
        win_lim[WIN_MEM]   = {{UPPER_W{1'b0}}, cfg_q.mem_lim};
        win_base[WIN_PREF] = {cfg_q.pf_ubase, cfg_q.pf_base};
        win_lim[WIN_PREF]  = {cfg_q.pf_ulim,  cfg_q.pf_lim};
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        mwd_window_cmp #(
            .KEY_W  (KEY_W),
            .GRAN_W (GRAN_W)
        ) i_cmp (
            .addr_i  (req_addr_i),
            .base_i  (win_base[w]),
            .limit_i (win_lim[w]),
            .match_o (win_match[w])
        );
    end

    mwd_resp i_resp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .en_i        (cfg_q.en),
        .match_i     (win_match),
        .rsp_o       (rsp)
    );

    assign rsp_valid_o = rsp.vld;
    assign rsp_hit_o   = rsp.hit;
    assign rsp_pref_o  = rsp.pref;
    assign rsp_wc_o    = rsp.wc;
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker
    import mwd_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input win_cfg_t          cfg_q,
    input logic              req_valid_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              rsp_valid_o,
    input logic              rsp_hit_o,
    input logic              rsp_pref_o,
    input logic              rsp_wc_o
);
    a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    a_r9_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o);

    a_r9_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rsp_valid_o |-> (!rsp_hit_o && !rsp_pref_o && !rsp_wc_o));

    a_r8_wc_only_pref_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_wc_o == (rsp_hit_o && rsp_pref_o));

    a_r5_disabled_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !cfg_q.en) |=> !rsp_hit_o);

    a_r3_low_window_below_4g: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && (req_addr_i[ADDR_W-1:32] != '0)) |=> !(rsp_hit_o && !rsp_pref_o));

    a_r6_inverted_pref_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && ({cfg_q.pf_ubase, cfg_q.pf_base} > {cfg_q.pf_ulim, cfg_q.pf_lim}))
        |=> !rsp_pref_o);
endmodule

bind mem_window_decoder mwd_checker i_mwd_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_q       (cfg_q),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_pref_o  (rsp_pref_o),
    .rsp_wc_o    (rsp_wc_o)
);

// File: tb/test_mem_window_decoder.sv
module test_mem_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_pref, rsp_wc;

    always #10 clk = ~clk;

    mem_window_decoder i_mem_window_decoder (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .req_valid_i (req_valid),
        .req_addr_i  (req_addr),
        .rsp_valid_o (rsp_valid),
        .rsp_hit_o   (rsp_hit),
        .rsp_pref_o  (rsp_pref),
        .rsp_wc_o    (rsp_wc)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference state, as the requirements define it.
    bit m_en;
    longint unsigned m_mb, m_ml, m_pb, m_pl, m_pub, m_pul;
    bit e_v, e_h, e_p, e_w, have_exp;
    string e_tag;

    function automatic void model_reset();
        m_en = 0; m_mb = 64'hFFF; m_ml = 0; m_pb = 64'hFFF; m_pl = 0;
        m_pub = 64'hFFFF_FFFF; m_pul = 0;
    endfunction

    function automatic void predict(input bit v, input longint unsigned a);
        longint unsigned lo, hi;
        bit in_m, in_p;
        lo = m_mb * 64'h10_0000;
        hi = m_ml * 64'h10_0000 + 64'hF_FFFF;
        in_m = (a >= lo) && (a <= hi);
        lo = m_pub * 64'h1_0000_0000 + m_pb * 64'h10_0000;
        hi = m_pul * 64'h1_0000_0000 + m_pl * 64'h10_0000 + 64'hF_FFFF;
        in_p = (a >= lo) && (a <= hi);
        e_v = v;
        e_h = v && m_en && (in_m || in_p);
        e_p = e_h && in_p;
        e_w = e_p;
    endfunction

    function automatic void model_write(input logic [2:0] sel, input logic [31:0] d);
        case (sel)
            3'd0: m_en  = d[0];
            3'd1: m_mb  = longint'(d[11:0]);
            3'd2: m_ml  = longint'(d[11:0]);
            3'd3: m_pb  = longint'(d[11:0]);
            3'd4: m_pl  = longint'(d[11:0]);
            3'd5: m_pub = longint'(d);
            3'd6: m_pul = longint'(d);
            default: ;
        endcase
    endfunction

    task automatic compare();
        if (have_exp) begin
            checks++;
            if ({rsp_valid, rsp_hit, rsp_pref, rsp_wc} !== {e_v, e_h, e_p, e_w}) begin
                errors++;
                $display("FAIL %s: got v=%0b hit=%0b pref=%0b wc=%0b, expected v=%0b hit=%0b pref=%0b wc=%0b",
                         e_tag, rsp_valid, rsp_hit, rsp_pref, rsp_wc, e_v, e_h, e_p, e_w);
            end
        end
    endtask

    task automatic step(input bit we, input logic [2:0] sel, input logic [31:0] d,
                        input bit rv, input logic [63:0] a, input string tag);
        @(negedge clk);
        compare();
        predict(rv, a);
        e_tag = tag;
        have_exp = 1'b1;
        if (we) model_write(sel, d);
        cfg_we = we; cfg_addr = sel; cfg_wdata = d;
        req_valid = rv; req_addr = a;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d, input string tag);
        step(1'b1, sel, d, 1'b0, 64'h0, tag);
    endtask

    task automatic rq(input logic [63:0] a, input string tag);
        step(1'b0, 3'd0, 32'h0, 1'b1, a, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got no completion, expected end of stimulus");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        have_exp = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs low while held in reset
        checks++;
        if ({rsp_valid, rsp_hit, rsp_pref, rsp_wc} !== 4'b0000) begin
            errors++;
            $display("FAIL R1: got %b expected 0000 in reset", {rsp_valid, rsp_hit, rsp_pref, rsp_wc});
        end
        rst_n = 1'b1;

        // R1: reset windows claim nothing even with enable set
        wr(3'd0, 32'h1, "R10");
        rq(64'h0, "R1");
        rq(64'hFFF0_0000, "R1");
        rq(64'hFFFF_FFFF_FFF0_0000, "R1");
        step(1'b0, 3'd0, 32'h0, 1'b0, 64'h0, "R9");

        // R2: inclusive 1 MB edges of the low window 0x100..0x1FF
        wr(3'd1, 32'hFFFF_F100, "R10");
        wr(3'd2, 32'h0000_01FF, "R10");
        rq(64'h1000_0000, "R2");
        rq(64'h0FFF_FFFF, "R2");
        rq(64'h1FFF_FFFF, "R2");
        rq(64'h2000_0000, "R2");
        // R3: same low bits with upper bits set
        rq(64'h1_1000_0000, "R3");
        rq(64'h8000_0000_1500_0000, "R3");

        // R4: prefetchable window above 4 GB
        wr(3'd5, 32'h1, "R10");
        wr(3'd3, 32'h0, "R10");
        wr(3'd6, 32'h1, "R10");
        wr(3'd4, 32'h0FF, "R10");
        rq(64'h1_0000_0000, "R4");
        rq(64'h1_0FFF_FFFF, "R4");
        rq(64'h1_1000_0000, "R4");
        rq(64'h0FFF_FFFF, "R4");
        rq(64'h2_0000_0000, "R4");

        // R7: overlap, prefetchable window moved to 0x180..0x2FF below 4 GB
        wr(3'd5, 32'h0, "R10");
        wr(3'd6, 32'h0, "R10");
        wr(3'd3, 32'h180, "R10");
        wr(3'd4, 32'h2FF, "R10");
        rq(64'h1800_0000, "R7");
        rq(64'h1FFF_FFFF, "R7");
        rq(64'h1000_0000, "R8");
        rq(64'h2FFF_FFFF, "R8");

        // R11: write and request in the same cycle use old values
        step(1'b1, 3'd0, 32'h0, 1'b1, 64'h1000_0000, "R11");
        rq(64'h1000_0000, "R5");
        rq(64'h1800_0000, "R5");
        step(1'b1, 3'd0, 32'h1, 1'b1, 64'h1800_0000, "R11");
        rq(64'h1800_0000, "R11");

        // R10: select 7 changes nothing
        wr(3'd7, 32'hFFFF_FFFF, "R10");
        rq(64'h1000_0000, "R10");
        rq(64'h2500_0000, "R10");

        // R6: inverted windows
        wr(3'd1, 32'h300, "R10");
        wr(3'd2, 32'h200, "R10");
        wr(3'd3, 32'h400, "R10");
        wr(3'd4, 32'h3FF, "R10");
        rq(64'h2000_0000, "R6");
        rq(64'h2800_0000, "R6");
        rq(64'h3000_0000, "R6");
        rq(64'h4000_0000, "R6");

        // R9: idle gaps between requests
        step(1'b0, 3'd0, 32'h0, 1'b0, 64'h4000_0000, "R9");
        rq(64'h4000_0000, "R9");
        step(1'b0, 3'd0, 32'h0, 1'b0, 64'h0, "R9");

        // R2: mixed writes and requests near small windows
        for (int i = 0; i < 400; i++) begin
            logic [2:0]  s;
            logic [31:0] d;
            logic [63:0] a;
            s = 3'($urandom_range(0, 7));
            d = (s == 3'd0) ? 32'($urandom_range(0, 3) != 0)
              : (s >= 3'd5) ? 32'($urandom_range(0, 2)) : 32'($urandom_range(0, 15));
            a = {30'h0, 2'($urandom_range(0, 2)), 12'($urandom_range(0, 16)), 20'h0};
            if ($urandom_range(0, 1) != 0) a[19:0] = 20'hF_FFFF;
            step(($urandom_range(0, 2) == 0), s, d, ($urandom_range(0, 3) != 0), a, "R2");
        end
        step(1'b0, 3'd0, 32'h0, 1'b0, 64'h0, "R9");
        @(negedge clk);
        compare();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule